// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer

This block is a 16-bit up-counter with a companion 16-bit capture/reload register and an 8-bit control/status register. It counts either a prescaled internal tick or falling edges seen on an external count pin. A second external pin acts as a trigger. In capture mode a trigger edge copies the running count into the companion register. In reload mode the companion register refills the counter, either when the count wraps past 0xFFFF or when a trigger edge arrives.

When either baud-clock enable is set, the block serves as a bit-rate source for a serial port. It always refills on overflow, never raises the overflow flag, ignores the trigger pin, and forwards its overflow pulses to the receive and/or transmit baud outputs. A baud output whose enable is clear passes an alternate overflow input through instead.

Software reaches the block through a byte-wide register port: write strobe, 3-bit address, write data and combinational read data. The interrupt request combines the two status flags with an external enable.

Top module: `cr_timer16`

## Requirements
- R1: After reset, the control register, the counter and the capture/reload register read 0, and irq is 0.
- R2: The register addresses are 0 for control, 1 and 2 for the counter's low and high bytes, and 3 and 4 for the capture/reload low and high bytes. Unused addresses read 0. Control bits are: 7 overflow flag, 6 trigger flag, 5 receive-baud enable, 4 transmit-baud enable, 3 trigger enable, 2 run, 1 source select, 0 capture select. Software can write and read back every control bit.
- R3: The counter advances by one for each count event, and only while run is 1. With source select 0 the count event is the internal tick, one every PRESCALE clocks. With source select 1 it is a falling edge on cnt_pin.
- R4: When the counter steps from 0xFFFF, the overflow flag is set. The counter becomes 0 if capture select is 1, or takes the capture/reload value if capture select is 0.
- R5: When trigger enable is 1 and capture select is 1, a falling edge on trig_pin copies the count into the capture/reload register and sets the trigger flag. The counter keeps its value and keeps running.
- R6: When trigger enable is 1 and capture select is 0, a falling edge on trig_pin loads the counter from the capture/reload register and sets the trigger flag.
- R7: When trigger enable is 0, trig_pin edges change neither the counter, the capture/reload register nor the trigger flag.
- R8: While either baud enable is 1, an overflow reloads the counter whatever capture select holds. The overflow flag is not set, and trig_pin edges have no effect.
- R9: rx_baud gives a one-clock pulse in the clock after each overflow while receive-baud enable is 1; otherwise it equals alt_ovf. tx_baud behaves the same way under transmit-baud enable.
- R10: Only a software write clears either flag. If a hardware set and a software write to control fall in the same cycle, the set wins.
- R11: irq equals irq_en AND (overflow flag OR (trigger flag AND NOT updown_en)).
- R12: A software write to either counter byte replaces that byte and cancels the same cycle's count step, together with any overflow, flag or reload it would have caused.
- R13: Both pins pass through SYNC_STAGES flops. A falling edge driven before clock edge 1 takes effect at clock edge SYNC_STAGES+1. At most one count event and one trigger event are taken per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cnt_pin | input | 1 | External count input, falling-edge active |
| trig_pin | input | 1 | External capture/reload trigger, falling-edge active |
| updown_en | input | 1 | Masks the trigger flag from the interrupt |
| irq_en | input | 1 | Interrupt enable |
| alt_ovf | input | 1 | Alternate timer overflow pulse for the baud outputs |
| irq | output | 1 | Interrupt request |
| rx_baud | output | 1 | Receive baud pulse |
| tx_baud | output | 1 | Transmit baud pulse |

## Verification
The assertions assume nothing about when the pins toggle, because the synchronizers absorb any timing. They do assume that a write strobe lasts exactly one clock with a stable address, and that control is not rewritten in the cycle they inspect. Their antecedents exclude cycles with a control write. The stimulus keeps every pin level for four clocks, so each falling edge gives exactly one event. It writes registers only between pulses, and writes into a count step only in the one directed case that targets R12.

// File: rtl/cr_timer_pkg.sv
package cr_timer_pkg;
  localparam int CW = 16;
  localparam int BW = 8;
  localparam int AW = 3;
  typedef logic [CW-1:0] cnt_t;

  localparam logic [AW-1:0] RA_CTRL   = 3'd0;
  localparam logic [AW-1:0] RA_CNT_LO = 3'd1;
  localparam logic [AW-1:0] RA_CNT_HI = 3'd2;
  localparam logic [AW-1:0] RA_CAP_LO = 3'd3;
  localparam logic [AW-1:0] RA_CAP_HI = 3'd4;

  localparam int B_TF   = 7;
  localparam int B_EXF  = 6;
  localparam int B_RXB  = 5;
  localparam int B_TXB  = 4;
  localparam int B_EXEN = 3;
  localparam int B_RUN  = 2;
  localparam int B_SEL  = 1;
  localparam int B_CAP  = 0;

  // Count one step up; on wrap either refill or go to zero.
  function automatic cnt_t step_next(cnt_t c, cnt_t refill, logic do_refill);
    if (&c) return do_refill ? refill : '0;
    return c + cnt_t'(1);
  endfunction

  // Replace one byte of a 16-bit value.
  function automatic cnt_t byte_merge(cnt_t v, logic hi, logic [BW-1:0] d);
    return hi ? {d, v[BW-1:0]} : {v[CW-1:BW], d};
  endfunction
endpackage

// File: rtl/cr_edge_sync.sv
module cr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sq;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq <= '1;
        else        sq <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq <= '1;
        else        sq <= {sq[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= sq[STAGES-1];
  end

  assign fall = prev & ~sq[STAGES-1];
endmodule

// File: rtl/cr_tick_gen.sv
module cr_tick_gen #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV < 2) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(DIV);
      logic [DW-1:0] ph;
      assign tick = (ph == DW'(DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ph <= '0;
        else if (tick) ph <= '0;
        else           ph <= ph + DW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/cr_count_core.sv
module cr_count_core
  import cr_timer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          trig_reload,
  input  logic          trig_capture,
  input  logic          ovf_refill,
  input  logic          cnt_wr_lo,
  input  logic          cnt_wr_hi,
  input  logic          cap_wr_lo,
  input  logic          cap_wr_hi,
  input  logic [BW-1:0] wdata,
  output cnt_t          cnt,
  output cnt_t          cap,
  output logic          ovf_evt
);
  logic sw_cnt;
  logic sw_cap;
  cnt_t cnt_n;
  cnt_t cap_n;

  assign sw_cnt  = cnt_wr_lo | cnt_wr_hi;
  assign sw_cap  = cap_wr_lo | cap_wr_hi;
  assign ovf_evt = step & (&cnt) & ~sw_cnt & ~trig_reload;

  always_comb begin
    cnt_n = cnt;
    if (sw_cnt)           cnt_n = byte_merge(cnt, cnt_wr_hi, wdata);
    else if (trig_reload) cnt_n = cap;
    else if (step)        cnt_n = step_next(cnt, cap, ovf_refill);
  end

  always_comb begin
    cap_n = cap;
    if (sw_cap)            cap_n = byte_merge(cap, cap_wr_hi, wdata);
    else if (trig_capture) cap_n = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      cap <= '0;
    end else begin
      cnt <= cnt_n;
      cap <= cap_n;
    end
  end
endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
  import cr_timer_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   reg_addr,
  input  logic         reg_wr,
  input  logic [7:0]   reg_wdata,
  output logic [7:0]   reg_rdata,
  input  logic         cnt_pin,
  input  logic         trig_pin,
  input  logic         updown_en,
  input  logic         irq_en,
  input  logic         alt_ovf,
  output logic         irq,
  output logic         rx_baud,
  output logic         tx_baud
);
  logic [BW-1:0] ctrl;
  logic [BW-1:0] ctrl_n;
  logic tick, cnt_fall, trig_fall;
  logic baud_mode, step, trig_evt, trig_capture, trig_reload, ovf_refill;
  logic ctrl_wr, cnt_wr_lo, cnt_wr_hi, cap_wr_lo, cap_wr_hi, sw_cnt, cap_sw;
  logic ovf_evt, ovf_q;
  cnt_t cnt, cap;

  cr_tick_gen #(.DIV(PRESCALE)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));
  cr_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall(cnt_fall));
  cr_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .pin(trig_pin), .fall(trig_fall));

  assign ctrl_wr   = reg_wr & (reg_addr == RA_CTRL);
  assign cnt_wr_lo = reg_wr & (reg_addr == RA_CNT_LO);
  assign cnt_wr_hi = reg_wr & (reg_addr == RA_CNT_HI);
  assign cap_wr_lo = reg_wr & (reg_addr == RA_CAP_LO);
  assign cap_wr_hi = reg_wr & (reg_addr == RA_CAP_HI);
  assign sw_cnt    = cnt_wr_lo | cnt_wr_hi;
  assign cap_sw    = cap_wr_lo | cap_wr_hi;

  assign baud_mode    = ctrl[B_RXB] | ctrl[B_TXB];
  assign step         = ctrl[B_RUN] & (ctrl[B_SEL] ? cnt_fall : tick);
  assign trig_evt     = trig_fall & ctrl[B_EXEN] & ~baud_mode;
  assign trig_capture = trig_evt & ctrl[B_CAP];
  assign trig_reload  = trig_evt & ~ctrl[B_CAP];
  assign ovf_refill   = baud_mode | ~ctrl[B_CAP];

  cr_count_core u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .trig_reload(trig_reload),
    .trig_capture(trig_capture), .ovf_refill(ovf_refill),
    .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi),
    .cap_wr_lo(cap_wr_lo), .cap_wr_hi(cap_wr_hi), .wdata(reg_wdata),
    .cnt(cnt), .cap(cap), .ovf_evt(ovf_evt));

  always_comb begin
    ctrl_n = ctrl_wr ? reg_wdata : ctrl;
    if (ovf_evt && !baud_mode) ctrl_n[B_TF]  = 1'b1;
    if (trig_evt)              ctrl_n[B_EXF] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      ovf_q <= 1'b0;
    end else begin
      ctrl  <= ctrl_n;
      ovf_q <= ovf_evt;
    end
  end

  assign rx_baud = ctrl[B_RXB] ? ovf_q : alt_ovf;
  assign tx_baud = ctrl[B_TXB] ? ovf_q : alt_ovf;
  assign irq     = irq_en & (ctrl[B_TF] | (ctrl[B_EXF] & ~updown_en));

  always_comb begin
    case (reg_addr)
      RA_CTRL:   reg_rdata = ctrl;
      RA_CNT_LO: reg_rdata = cnt[BW-1:0];
      RA_CNT_HI: reg_rdata = cnt[CW-1:BW];
      RA_CAP_LO: reg_rdata = cap[BW-1:0];
      RA_CAP_HI: reg_rdata = cap[CW-1:BW];
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cr_timer16_chk.sv
module cr_timer16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  ctrl,
  input logic [15:0] cnt,
  input logic [15:0] cap,
  input logic        ovf_evt,
  input logic        trig_evt,
  input logic        trig_capture,
  input logic        ctrl_wr,
  input logic        cap_sw,
  input logic        sw_cnt,
  input logic        step,
  input logic        baud_mode,
  input logic        irq,
  input logic        irq_en,
  input logic        rx_baud
);
  // R4: overflow outside baud mode raises the overflow flag
  a_r4_flag_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && !baud_mode |=> ctrl[7]);
  // R8: in baud mode the overflow flag cannot rise by itself
  a_r8_no_flag_in_baud: assert property (@(posedge clk) disable iff (!rst_n)
    baud_mode && !ctrl_wr && !ctrl[7] |=> !ctrl[7]);
  // R5: capture stores the count of the trigger cycle
  a_r5_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    trig_capture && !cap_sw |=> cap == $past(cnt));
  // R10: a trigger action sets the trigger flag even against a write
  a_r10_trig_flag: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |=> ctrl[6]);
  // R11: no request without enable
  a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  // R9: overflow reaches rx_baud one clock later
  a_r9_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && ctrl[5] && !ctrl_wr |=> rx_baud);
  // R3: without a step, write or trigger the count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !sw_cnt && !trig_evt |=> $stable(cnt));
endmodule

bind cr_timer16 cr_timer16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .cnt(cnt), .cap(cap),
  .ovf_evt(ovf_evt), .trig_evt(trig_evt), .trig_capture(trig_capture),
  .ctrl_wr(ctrl_wr), .cap_sw(cap_sw), .sw_cnt(sw_cnt), .step(step),
  .baud_mode(baud_mode), .irq(irq), .irq_en(irq_en), .rx_baud(rx_baud));

// File: tb/cr_timer16_tb.sv
`timescale 1ns/1ps
module cr_timer16_tb;
  localparam int PS = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic cnt_pin = 1'b1, trig_pin = 1'b1, updown_en = 1'b0, irq_en = 1'b0, alt_ovf = 1'b0;
  logic irq, rx_baud, tx_baud;
  int checks = 0, fails = 0, rx_n = 0, tx_n = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cr_timer16 #(.PRESCALE(PS), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .updown_en(updown_en), .irq_en(irq_en),
    .alt_ovf(alt_ovf), .irq(irq), .rx_baud(rx_baud), .tx_baud(tx_baud));

  always @(negedge clk) begin
    if (rx_baud) rx_n++;
    if (tx_baud) tx_n++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l); rd(lo + 3'd1, h); v = {h, l};
  endtask

  task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
    wr(lo, v[7:0]); wr(lo + 3'd1, v[15:8]);
  endtask

  task automatic cnt_pulse();
    @(negedge clk); cnt_pin = 1'b0; repeat (4) @(negedge clk);
    cnt_pin = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic trig_pulse();
    @(negedge clk); trig_pin = 1'b0; repeat (4) @(negedge clk);
    trig_pin = 1'b1; repeat (4) @(negedge clk);
  endtask

  // Bench restatement of stepping: returns {overflow seen, final count}
  function automatic logic [16:0] model(logic [15:0] s, logic [15:0] c, int n, logic refill);
    logic [15:0] v = s;
    logic o = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (v == 16'hFFFF) begin o = 1'b1; v = refill ? c : 16'h0; end
      else v = v + 16'd1;
    end
    return {o, v};
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    logic [16:0] m;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(3'd0, b); chk("R1 ctrl", b, 8'h00);
    rd16(3'd1, v); chk("R1 count", v, 16'h0);
    rd16(3'd3, v); chk("R1 cap", v, 16'h0);
    chk("R1 irq", irq, 1'b0);
    // R2 readback and unused address
    wr(3'd0, 8'h39); rd(3'd0, b); chk("R2 ctrl readback", b, 8'h39);
    wr(3'd0, 8'h00);
    rd(3'd6, b); chk("R2 unused addr", b, 8'h00);

    // R3 counter source, run gating
    wr16(3'd1, 16'h0010); wr(3'd0, 8'h06);
    repeat (5) cnt_pulse();
    rd16(3'd1, v); chk("R3 pin count", v, 16'h0015);
    wr(3'd0, 8'h02);
    repeat (3) cnt_pulse();
    rd16(3'd1, v); chk("R3 run off holds", v, 16'h0015);
    // R3 internal tick
    wr16(3'd1, 16'h0000); wr(3'd0, 8'h04);
    repeat (10 * PS - 1) @(negedge clk);
    wr(3'd0, 8'h00);
    rd16(3'd1, v);
    checks++;
    if (v < 16'd9 || v > 16'd11) begin
      fails++; $display("FAIL R3 tick count actual=%0d expected=9..11", v);
    end

    // R4 reload on overflow, R11 irq
    wr16(3'd3, 16'h1234); wr16(3'd1, 16'hFFFE); wr(3'd0, 8'h06);
    repeat (3) cnt_pulse();
    rd16(3'd1, v); chk("R4 reload value", v, 16'h1235);
    rd(3'd0, b); chk("R4 flag set", b, 8'h86);
    irq_en = 1'b1; #1; chk("R11 irq from tf", irq, 1'b1);
    // R10 software clear
    wr(3'd0, 8'h06); rd(3'd0, b); chk("R10 clear tf", b, 8'h06);
    chk("R11 irq low", irq, 1'b0);
    // R4 capture mode wraps to zero
    wr(3'd0, 8'h07); wr16(3'd1, 16'hFFFF);
    repeat (2) cnt_pulse();
    rd16(3'd1, v); chk("R4 wrap zero", v, 16'h0001);
    rd(3'd0, b); chk("R4 flag capture mode", b, 8'h87);
    wr(3'd0, 8'h00);

    // R5 capture on trigger
    wr16(3'd1, 16'h0ABC); wr(3'd0, 8'h0F);
    trig_pulse();
    rd16(3'd3, v); chk("R5 captured", v, 16'h0ABC);
    rd16(3'd1, v); chk("R5 count kept", v, 16'h0ABC);
    rd(3'd0, b); chk("R5 exf", b, 8'h4F);
    updown_en = 1'b1; #1; chk("R11 updown mask", irq, 1'b0);
    updown_en = 1'b0; #1; chk("R11 exf irq", irq, 1'b1);
    wr(3'd0, 8'h00);

    // R6 reload on trigger
    wr16(3'd3, 16'h2222); wr16(3'd1, 16'h0100); wr(3'd0, 8'h0E);
    trig_pulse();
    rd16(3'd1, v); chk("R6 trigger reload", v, 16'h2222);
    rd(3'd0, b); chk("R6 exf", b, 8'h4E);
    // R7 trigger ignored
    wr(3'd0, 8'h06); wr16(3'd1, 16'h0300);
    trig_pulse();
    rd16(3'd1, v); chk("R7 count", v, 16'h0300);
    rd16(3'd3, v); chk("R7 cap", v, 16'h2222);
    rd(3'd0, b); chk("R7 ctrl", b, 8'h06);

    // R8/R9 baud mode
    wr(3'd0, 8'h00); wr16(3'd3, 16'hFFF0); wr16(3'd1, 16'hFFFE);
    wr(3'd0, 8'h2F);
    rx_n = 0; tx_n = 0;
    repeat (20) cnt_pulse();
    rd16(3'd1, v); chk("R8 forced reload", v, 16'hFFF2);
    rd(3'd0, b); chk("R8 no tf", b, 8'h2F);
    chk("R9 rx pulses", rx_n, 2);
    chk("R9 tx follows alt idle", tx_n, 0);
    trig_pulse();
    rd16(3'd1, v); chk("R8 trig ignored cnt", v, 16'hFFF2);
    rd16(3'd3, v); chk("R8 trig ignored cap", v, 16'hFFF0);
    rd(3'd0, b); chk("R8 trig no exf", b, 8'h2F);
    @(negedge clk); alt_ovf = 1'b1; #1;
    chk("R9 tx = alt", tx_baud, 1'b1);
    chk("R9 rx not alt", rx_baud, 1'b0);
    @(negedge clk); alt_ovf = 1'b0;
    wr(3'd0, 8'h00);

    // R12 write beats overflow step
    wr16(3'd1, 16'hFFFF); wr(3'd0, 8'h06);
    @(negedge clk); cnt_pin = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_addr = 3'd1; reg_wdata = 8'h55; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    repeat (3) @(negedge clk); cnt_pin = 1'b1; repeat (4) @(negedge clk);
    rd16(3'd1, v); chk("R12 write wins", v, 16'hFF55);
    rd(3'd0, b); chk("R12 no flag", b, 8'h06);

    // R13 edge latency
    wr16(3'd1, 16'h0040);
    @(negedge clk); reg_addr = 3'd1; cnt_pin = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R13 before third edge", reg_rdata, 8'h40);
    @(posedge clk); #1;
    chk("R13 at third edge", reg_rdata, 8'h41);
    repeat (3) @(negedge clk); cnt_pin = 1'b1; repeat (4) @(negedge clk);
    wr(3'd0, 8'h00);

    // Random runs against the bench model (R3, R4)
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'd7);
    end
    for (int it = 0; it < 20; it++) begin
      logic [15:0] s, c;
      int n;
      logic cs;
      s = $urandom; c = $urandom;
      if (it % 2 == 0) s = 16'hFFE0 | 16'($urandom_range(0, 31));
      n = $urandom_range(0, 40);
      cs = 1'($urandom_range(0, 1));
      wr16(3'd3, c); wr16(3'd1, s);
      wr(3'd0, {7'b0000011, cs});
      for (int k = 0; k < n; k++) cnt_pulse();
      m = model(s, c, n, ~cs);
      rd16(3'd1, v); chk("R3 random count", v, m[15:0]);
      rd(3'd0, b); chk("R4 random flag", b[7], m[16]);
      wr(3'd0, 8'h00);
    end

    finish_up();
  end
endmodule